// File: doc/BRIEF.md
# Wired-OR Handshake Transceiver with Release-Edge Glitch Filter

This block is a clocked model of a six-bit handshake transceiver for an open-collector backplane, where any board can pull a line low and the line floats high only once every board has let go. On the transmit side, an active-low enable gates six data bits onto per-line pull-down controls. On the receive side, the sampled bus levels pass through a synchronizer and come out inverted, so a pulled-low line reads as logic one.

Lines 0 to 2 also have a second, filtered receive output. When a line is released, the rising bus level can ring back low several times while the remaining drivers let go. The filtered output therefore drops only after the line has stayed high for a whole chosen number of clock cycles. An assertion of the line passes through with no extra delay. A two-bit select picks one of four rejection widths. Filtered and unfiltered copies of lines 0 to 2 are available at the same time, so handshake logic can use whichever one it needs.

Top module: `wor_handshake_xcvr`

## Requirements
- R1: While `drv_en_n` is high, all `pull_dn` bits are 0 one clock after the edge that samples it, whatever `drv_data` holds.
- R2: While `drv_en_n` is low, `pull_dn[i]` equals `drv_data[i]` one clock after the sampling edge (1 = line pulled low).
- R3: `rx_raw[i]` is the inverse of `bus_in[i]` for all six lines. It updates on the third rising edge after `bus_in` changes, counting the capturing edge as the first, and no pulse is rejected.
- R4: When line i (i = 0..2) goes low, `rx_filt[i]` rises on the same edge as `rx_raw[i]`, for every select setting.
- R5: `width_sel` chooses the rejection width N, with `width_sel[1]` as the MSB: 0 gives 5 cycles, 1 gives 10, 2 gives 14 and 3 gives 20.
- R6: When a filtered line is released and stays high for N consecutive synchronized samples, `rx_filt[i]` falls on the (N+2)th rising edge after the release is presented.
- R7: When a released line is pulled low again after only N-1 high samples, `rx_filt[i]` stays high throughout.
- R8: `width_sel` is taken into an internal register only on edges where all three filter counters are idle. A change made while a release is being timed does not alter that release's width.
- R9: While reset is active, `pull_dn`, `rx_raw` and `rx_filt` are all 0, which corresponds to an idle high bus with nothing driving it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_data | input | 6 | Transmit data, 1 = pull the line low |
| drv_en_n | input | 1 | Active-low driver enable |
| width_sel | input | 2 | Filter width select |
| bus_in | input | 6 | Sampled bus levels, 1 = line high |
| pull_dn | output | 6 | Open-collector pull-down enables |
| rx_raw | output | 6 | Unfiltered, inverted receive bits |
| rx_filt | output | 3 | Filtered receive bits for lines 0 to 2 |

## Verification
A filter counter that is off by one, or that fails to clear when the line is pulled low again, shows up at `rx_filt` as a fall one cycle early or late, or as a short release that is not rejected. Either is visible within N+2 cycles of the release. A select register that updates in the middle of a count changes the fall cycle of the release already being timed. If it only ever loads while idle, the new width appears on the next release. Latency faults in the synchronizer or in the output registers move `rx_raw` and the rising edge of `rx_filt` away from the third edge, and they show up on the very first transition.

// File: rtl/wor_hs_pkg.sv
package wor_hs_pkg;

  // Map the two-bit select to a rejection width in cycles.
  function automatic int unsigned sel_width(input logic [1:0] sel,
                                            input int unsigned w0,
                                            input int unsigned w1,
                                            input int unsigned w2,
                                            input int unsigned w3);
    case (sel)
      2'd0:    return w0;
      2'd1:    return w1;
      2'd2:    return w2;
      default: return w3;
    endcase
  endfunction

  function automatic int unsigned max_of4(input int unsigned a,
                                          input int unsigned b,
                                          input int unsigned c,
                                          input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/wor_hs_driver.sv
module wor_hs_driver #(
  parameter int NB = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] data,
  input  logic          en_n,
  output logic [NB-1:0] pull_dn
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pull_dn <= '0;
    else if (en_n) pull_dn <= '0;
    else           pull_dn <= data;
  end
endmodule

// File: rtl/wor_hs_sync.sv
module wor_hs_sync #(
  parameter int NB     = 6,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] d,
  output logic [NB-1:0] q
);
  logic [NB-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '1;  // idle bus floats high
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/wor_hs_release_filter.sv
module wor_hs_release_filter #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_low,
  input  logic [CW-1:0] width,
  output logic          rx,
  output logic          idle
);
  logic [CW-1:0] cnt;
  logic          last_hi;

  // The current sample is the last of the required run of high samples.
  assign last_hi = (cnt == width - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      rx  <= 1'b0;
    end else if (bus_low) begin
      cnt <= '0;
      rx  <= 1'b1;
    end else if (rx) begin
      if (last_hi) begin
        cnt <= '0;
        rx  <= 1'b0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign idle = (cnt == '0);
endmodule

// File: rtl/wor_handshake_xcvr.sv
module wor_handshake_xcvr
  import wor_hs_pkg::*;
#(
  parameter int          NB          = 6,
  parameter int          NF          = 3,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned FW0         = 5,
  parameter int unsigned FW1         = 10,
  parameter int unsigned FW2         = 14,
  parameter int unsigned FW3         = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] drv_data,
  input  logic          drv_en_n,
  input  logic [1:0]    width_sel,
  input  logic [NB-1:0] bus_in,
  output logic [NB-1:0] pull_dn,
  output logic [NB-1:0] rx_raw,
  output logic [NF-1:0] rx_filt
);
  localparam int unsigned FW_MAX = max_of4(FW0, FW1, FW2, FW3);
  localparam int          CW     = $clog2(FW_MAX + 1);

  logic [NB-1:0] bus_s;
  logic [1:0]    sel_q;
  logic [CW-1:0] fwidth;
  logic [NF-1:0] filt_idle;
  logic          all_idle;

  wor_hs_driver #(.NB(NB)) u_drv (
    .clk     (clk),
    .rst_n   (rst_n),
    .data    (drv_data),
    .en_n    (drv_en_n),
    .pull_dn (pull_dn)
  );

  wor_hs_sync #(.NB(NB), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (bus_in),
    .q     (bus_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_raw <= '0;
    else        rx_raw <= ~bus_s;
  end

  assign all_idle = &filt_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sel_q <= '0;
    else if (all_idle) sel_q <= width_sel;
  end

  assign fwidth = CW'(sel_width(sel_q, FW0, FW1, FW2, FW3));

  for (genvar g = 0; g < NF; g++) begin : g_filt
    wor_hs_release_filter #(.CW(CW)) u_flt (
      .clk     (clk),
      .rst_n   (rst_n),
      .bus_low (~bus_s[g]),
      .width   (fwidth),
      .rx      (rx_filt[g]),
      .idle    (filt_idle[g])
    );
  end
endmodule

// File: rtl/wor_handshake_xcvr_chk.sv
module wor_handshake_xcvr_chk #(
  parameter int NB = 6,
  parameter int NF = 3,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NB-1:0] drv_data,
  input logic          drv_en_n,
  input logic [NB-1:0] pull_dn,
  input logic [NB-1:0] rx_raw,
  input logic [NF-1:0] rx_filt,
  input logic [NB-1:0] bus_s,
  input logic [1:0]    sel_q,
  input logic [CW-1:0] fwidth,
  input logic          all_idle
);
  // Run length of consecutive high synchronized samples per filtered line.
  logic [CW-1:0] hi_run [NF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NF; k++) hi_run[k] <= '0;
    end else begin
      for (int k = 0; k < NF; k++) begin
        if (!bus_s[k])            hi_run[k] <= '0;
        else if (hi_run[k] != '1) hi_run[k] <= hi_run[k] + CW'(1);
      end
    end
  end

  p_off_when_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en_n |=> (pull_dn == '0));

  p_drive_follows_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en_n |=> (pull_dn == $past(drv_data)));

  p_raw_inverts_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_raw == ~$past(bus_s));

  p_sel_held_while_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !all_idle |=> $stable(sel_q));

  for (genvar g = 0; g < NF; g++) begin : g_chk
    p_assert_passes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_s[g] |=> rx_filt[g]);

    p_fall_after_full_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_filt[g]) |-> (hi_run[g] >= fwidth));
  end
endmodule

bind wor_handshake_xcvr wor_handshake_xcvr_chk #(.NB(NB), .NF(NF), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .drv_data (drv_data),
  .drv_en_n (drv_en_n),
  .pull_dn  (pull_dn),
  .rx_raw   (rx_raw),
  .rx_filt  (rx_filt),
  .bus_s    (bus_s),
  .sel_q    (sel_q),
  .fwidth   (fwidth),
  .all_idle (all_idle)
);

// File: tb/wor_handshake_xcvr_tb.sv
`timescale 1ns/1ps
module wor_handshake_xcvr_tb;
  localparam int NB = 6;
  localparam int NF = 3;

  // {select, release width, expect accepted}; widths 5/10/14/20 per R5
  localparam logic [7:0] VEC [8] = '{
    {2'd0, 5'd4,  1'b0}, {2'd0, 5'd5,  1'b1},
    {2'd1, 5'd9,  1'b0}, {2'd1, 5'd10, 1'b1},
    {2'd2, 5'd13, 1'b0}, {2'd2, 5'd14, 1'b1},
    {2'd3, 5'd19, 1'b0}, {2'd3, 5'd20, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NB-1:0] drv_data;
  logic          drv_en_n;
  logic [1:0]    width_sel;
  logic [NB-1:0] bus_in;
  wire  [NB-1:0] pull_dn;
  wire  [NB-1:0] rx_raw;
  wire  [NF-1:0] rx_filt;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  wor_handshake_xcvr u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .drv_data  (drv_data),
    .drv_en_n  (drv_en_n),
    .width_sel (width_sel),
    .bus_in    (bus_in),
    .pull_dn   (pull_dn),
    .rx_raw    (rx_raw),
    .rx_filt   (rx_filt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic run_vec(input int i);
    logic [1:0] s;
    int         w;
    bit         acc;
    int         b;
    int         first_low;
    s         = VEC[i][7:6];
    w         = int'(VEC[i][5:1]);
    acc       = VEC[i][0];
    b         = i % 3;
    first_low = 0;
    width_sel = s;
    tick(3);
    bus_in[b] = 1'b0;
    tick(2);
    chk("R4 filt rise not before third edge", 32'(rx_filt[b]), 32'd0);
    tick(1);
    chk("R4 filt rises with raw", 32'(rx_filt[b]), 32'd1);
    chk("R3 raw follows low bus", 32'(rx_raw[b]), 32'd1);
    tick(2);
    bus_in[b] = 1'b1;
    for (int c = 1; c <= w + 4; c++) begin
      tick(1);
      if (first_low == 0 && rx_filt[b] == 1'b0) first_low = c;
      if (c == w) bus_in[b] = 1'b0;
    end
    if (acc) chk("R6 release of N accepted at edge N+2", 32'(first_low), 32'(w + 2));
    else     chk("R7 release of N-1 rejected", 32'(first_low), 32'd0);
    chk("R4 filt high again after reassert", 32'(rx_filt[b]), 32'd1);
    bus_in[b] = 1'b1;
    tick(25);
    chk("R6 filt low after long release", 32'(rx_filt[b]), 32'd0);
  endtask

  initial begin : main
    int first_low;
    rst_n     = 1'b0;
    drv_data  = '1;
    drv_en_n  = 1'b0;
    bus_in    = '1;
    width_sel = 2'd0;
    tick(3);
    chk("R9 pull_dn in reset", 32'(pull_dn), 32'd0);
    chk("R9 rx_raw in reset", 32'(rx_raw), 32'd0);
    chk("R9 rx_filt in reset", 32'(rx_filt), 32'd0);
    drv_data = '0;
    rst_n    = 1'b1;
    tick(3);
    chk("R9 rx_filt idle after reset", 32'(rx_filt), 32'd0);

    drv_en_n = 1'b1;
    drv_data = '1;
    tick(1);
    chk("R1 disabled with all data high", 32'(pull_dn), 32'd0);
    drv_en_n = 1'b0;
    drv_data = 6'b101101;
    tick(1);
    chk("R2 drive pattern a", 32'(pull_dn), 32'h2D);
    drv_data = 6'b010010;
    tick(1);
    chk("R2 drive pattern b", 32'(pull_dn), 32'h12);
    drv_en_n = 1'b1;
    tick(1);
    chk("R1 disable releases all", 32'(pull_dn), 32'd0);

    bus_in = 6'b011010;
    tick(2);
    chk("R3 raw unchanged before third edge", 32'(rx_raw), 32'd0);
    tick(1);
    chk("R3 raw inverted pattern", 32'(rx_raw), 32'h25);
    bus_in = '1;
    tick(3);
    chk("R3 raw back to idle", 32'(rx_raw), 32'd0);
    tick(10);
    chk("R6 filters settled", 32'(rx_filt), 32'd0);

    for (int i = 0; i < 8; i++) run_vec(i);

    // R8: a select change during a count leaves that count at width 5
    width_sel = 2'd0;
    tick(3);
    bus_in[0] = 1'b0;
    tick(4);
    bus_in[0] = 1'b1;
    first_low = 0;
    for (int c = 1; c <= 10; c++) begin
      tick(1);
      if (c == 4) width_sel = 2'd3;
      if (first_low == 0 && rx_filt[0] == 1'b0) first_low = c;
    end
    chk("R8 mid-count select change ignored", 32'(first_low), 32'd7);
    tick(3);
    bus_in[0] = 1'b0;
    tick(4);
    bus_in[0] = 1'b1;
    first_low = 0;
    for (int c = 1; c <= 9; c++) begin
      tick(1);
      if (first_low == 0 && rx_filt[0] == 1'b0) first_low = c;
      if (c == 5) bus_in[0] = 1'b0;
    end
    chk("R8 new width 20 applied when idle", 32'(first_low), 32'd0);
    bus_in[0] = 1'b1;
    tick(30);
    chk("R8 filt low after long release", 32'(rx_filt[0]), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule